// File: doc/BRIEF.md
# MAC Raw Interrupt Status Aggregator

This block collects interrupt-worthy events from an Ethernet MAC into one read-only 32-bit raw status word and a single combined interrupt line. Two of its bits are sticky flags with their own clearing rules. The low-power-idle flag is cleared as a side effect of software reading a flag in a separate LPI register. The timestamp flag is cleared when a read of this word completes, or when software reads the overflow flag in the timestamp status register. The remaining bits are live summaries of level inputs from the statistics-counter blocks and the power-management logic.

The timestamp flag is raised by a built-in comparator. The comparator checks the running system time (seconds, then nanoseconds) against a programmed target. It produces one event on the first cycle that the time reaches or passes the target. In advanced timestamp mode, an overflow of the target-seconds value also raises the flag. A per-bit mask register, at a second address of the same register port, decides which status bits drive the interrupt output.

Top module: `mac_irq_status`

## Requirements
- R1: After reset, the status word reads 0, the mask reads 0 and `irq_o` is 0.
- R2: Only bits 10, 9, 6, 5, 4 and 3 are implemented, so every other bit of `rd_data` is always 0. Writing all ones to the mask reads back as 0x0000_0678.
- R3: Status bit 10 sets one cycle after a pulse on `lpi_tx_chg` or `lpi_rx_chg`. A read of the status word leaves it unchanged.
- R4: Status bit 10 clears one cycle after `lpi_flag_rd`. If a transition pulse arrives in the same cycle as `lpi_flag_rd`, the bit stays set.
- R5: Status bit 9 sets when the system time becomes greater than or equal to the target. Seconds are compared first, and nanoseconds only when the seconds are equal. The flag sets once per rising edge of that condition, so a condition that stays true does not set it again after it is cleared.
- R6: While `adv_ts_mode` is 1, a pulse on `tgt_sec_ovf` sets bit 9. While `adv_ts_mode` is 0, that pulse has no effect.
- R7: Bit 9 clears at the clock edge that completes a status read, or one cycle after `ts_ovf_rd`. A set event in the same cycle as either clear wins, and the bit stays set.
- R8: Bit 6 equals the OR of `mmc_tx_irq`. Bit 5 equals the OR of `mmc_rx_irq`. Bit 4 equals bit 5 OR bit 6.
- R9: Bit 3 follows the `pmt_evt` level.
- R10: Reads have one cycle of latency. Address 0 returns the status word, address 1 returns the mask, and any other address returns 0. A write to address 1 loads the mask. `irq_o` is the OR of the status bits whose mask bit is 0, where a mask bit of 1 suppresses that status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (mask register only) |
| addr | input | ADDR_W | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| lpi_tx_chg | input | 1 | Transmitter entered or left low-power idle (pulse) |
| lpi_rx_chg | input | 1 | Receiver entered or left low-power idle (pulse) |
| lpi_flag_rd | input | 1 | Software read the transmit LPI entry flag (pulse) |
| sys_sec | input | SEC_W | System time, seconds |
| sys_ns | input | NS_W | System time, nanoseconds |
| tgt_sec | input | SEC_W | Target time, seconds |
| tgt_ns | input | NS_W | Target time, nanoseconds |
| adv_ts_mode | input | 1 | Advanced timestamp mode enable |
| tgt_sec_ovf | input | 1 | Target seconds overflow (pulse) |
| ts_ovf_rd | input | 1 | Software read the timestamp overflow flag (pulse) |
| mmc_tx_irq | input | TX_W | Transmit counter interrupt bits |
| mmc_rx_irq | input | RX_W | Receive counter interrupt bits |
| pmt_evt | input | 1 | Power-management event level |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The bench targets the time comparison where the seconds are smaller but the nanoseconds are larger. A design that compares the fields independently would raise bit 9 there. After a timestamp flag has been read away, the bench holds the match condition true. A level-triggered design would set the flag again at once. The bench drives a set event in the same cycle as each kind of clear: a status read, an overflow-flag read and an LPI-flag read. A design that gives the clear priority would lose the event and read 0. The bench also checks that a status read leaves the LPI bit set, and that an overflow in default mode is ignored.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
    localparam int DATA_W   = 32;
    localparam int BIT_LPI  = 10;
    localparam int BIT_TS   = 9;
    localparam int BIT_TXC  = 6;
    localparam int BIT_RXC  = 5;
    localparam int BIT_ANYC = 4;
    localparam int BIT_PMT  = 3;

    localparam logic [DATA_W-1:0] IMPL_MASK =
        (DATA_W'(1) << BIT_LPI) | (DATA_W'(1) << BIT_TS)  |
        (DATA_W'(1) << BIT_TXC) | (DATA_W'(1) << BIT_RXC) |
        (DATA_W'(1) << BIT_ANYC) | (DATA_W'(1) << BIT_PMT);

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] rdata;
    } regs_t;
endpackage

// File: rtl/mac_irq_sticky.sv
module mac_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;   // set wins over clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/mac_irq_tcmp.sv
module mac_irq_tcmp #(
    parameter int SEC_W = 32,
    parameter int NS_W  = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] sys_sec,
    input  logic [NS_W-1:0]  sys_ns,
    input  logic [SEC_W-1:0] tgt_sec,
    input  logic [NS_W-1:0]  tgt_ns,
    output logic             hit_o
);
    logic ge_d, ge_q;

    always_comb begin
        if (sys_sec != tgt_sec) ge_d = (sys_sec > tgt_sec);
        else                    ge_d = (sys_ns >= tgt_ns);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ge_q <= 1'b0;
        else        ge_q <= ge_d;
    end

    // single-cycle event on the first cycle the condition holds
    assign hit_o = ge_d & ~ge_q;
endmodule

// File: rtl/mac_irq_status.sv
module mac_irq_status
    import mac_irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SEC_W  = 32,
    parameter int NS_W   = 30,
    parameter int TX_W   = 18,
    parameter int RX_W   = 18,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 0,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic              lpi_tx_chg,
    input  logic              lpi_rx_chg,
    input  logic              lpi_flag_rd,
    input  logic [SEC_W-1:0]  sys_sec,
    input  logic [NS_W-1:0]   sys_ns,
    input  logic [SEC_W-1:0]  tgt_sec,
    input  logic [NS_W-1:0]   tgt_ns,
    input  logic              adv_ts_mode,
    input  logic              tgt_sec_ovf,
    input  logic              ts_ovf_rd,
    input  logic [TX_W-1:0]   mmc_tx_irq,
    input  logic [RX_W-1:0]   mmc_rx_irq,
    input  logic              pmt_evt,
    output logic              irq_o
);
    regs_t regs_d, regs_q;

    logic stat_rd;
    logic ts_hit, ts_set, ts_clr, ts_flag;
    logic lpi_set, lpi_flag;
    logic tx_any, rx_any;
    logic [DATA_W-1:0] status_w;

    assign stat_rd = rd_en && (addr == STAT_ADDR);

    mac_irq_tcmp #(.SEC_W(SEC_W), .NS_W(NS_W)) u_tcmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .sys_sec (sys_sec),
        .sys_ns  (sys_ns),
        .tgt_sec (tgt_sec),
        .tgt_ns  (tgt_ns),
        .hit_o   (ts_hit)
    );

    assign ts_set = ts_hit | (adv_ts_mode & tgt_sec_ovf);
    assign ts_clr = stat_rd | ts_ovf_rd;

    mac_irq_sticky u_ts_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ts_set),
        .clr_i  (ts_clr),
        .flag_o (ts_flag)
    );

    assign lpi_set = lpi_tx_chg | lpi_rx_chg;

    mac_irq_sticky u_lpi_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (lpi_set),
        .clr_i  (lpi_flag_rd),
        .flag_o (lpi_flag)
    );

    assign tx_any = |mmc_tx_irq;
    assign rx_any = |mmc_rx_irq;

    always_comb begin
        status_w           = '0;
        status_w[BIT_LPI]  = lpi_flag;
        status_w[BIT_TS]   = ts_flag;
        status_w[BIT_TXC]  = tx_any;
        status_w[BIT_RXC]  = rx_any;
        status_w[BIT_ANYC] = tx_any | rx_any;
        status_w[BIT_PMT]  = pmt_evt;
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_en && (addr == MASK_ADDR))
            regs_d.mask = wr_data & IMPL_MASK;
        if (rd_en) begin
            if (addr == STAT_ADDR)      regs_d.rdata = status_w;
            else if (addr == MASK_ADDR) regs_d.rdata = regs_q.mask;
            else                        regs_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rd_data = regs_q.rdata;
    assign irq_o   = |(status_w & ~regs_q.mask);
endmodule

// File: rtl/mac_irq_status_chk.sv
module mac_irq_status_chk
    import mac_irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SEC_W  = 32,
    parameter int NS_W   = 30,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rd_data,
    input logic              lpi_tx_chg,
    input logic              lpi_rx_chg,
    input logic              lpi_flag_rd,
    input logic [SEC_W-1:0]  sys_sec,
    input logic [NS_W-1:0]   sys_ns,
    input logic [SEC_W-1:0]  tgt_sec,
    input logic [NS_W-1:0]   tgt_ns,
    input logic              adv_ts_mode,
    input logic              tgt_sec_ovf,
    input logic [31:0]       status,
    input logic [31:0]       mask,
    input logic              irq_o
);
    logic time_ge;
    assign time_ge = (sys_sec > tgt_sec) || ((sys_sec == tgt_sec) && (sys_ns >= tgt_ns));

    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~IMPL_MASK) == '0);

    assert_lpi_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lpi_tx_chg || lpi_rx_chg) |=> status[BIT_LPI]);

    assert_lpi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_LPI] && !lpi_flag_rd) |=> status[BIT_LPI]);

    assert_lpi_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lpi_flag_rd && !lpi_tx_chg && !lpi_rx_chg) |=> !status[BIT_LPI]);

    assert_ts_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[BIT_TS]) |-> $past(time_ge || (adv_ts_mode && tgt_sec_ovf)));

    assert_ts_rdclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == STAT_ADDR && !time_ge && !(adv_ts_mode && tgt_sec_ovf))
        |=> !status[BIT_TS]);

    assert_rd_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == STAT_ADDR) |=> rd_data == $past(status));

    assert_irq_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(status & ~mask & IMPL_MASK));
endmodule

bind mac_irq_status mac_irq_status_chk #(
    .ADDR_W(ADDR_W), .SEC_W(SEC_W), .NS_W(NS_W), .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .addr        (addr),
    .rd_data     (rd_data),
    .lpi_tx_chg  (lpi_tx_chg),
    .lpi_rx_chg  (lpi_rx_chg),
    .lpi_flag_rd (lpi_flag_rd),
    .sys_sec     (sys_sec),
    .sys_ns      (sys_ns),
    .tgt_sec     (tgt_sec),
    .tgt_ns      (tgt_ns),
    .adv_ts_mode (adv_ts_mode),
    .tgt_sec_ovf (tgt_sec_ovf),
    .status      (status_w),
    .mask        (regs_q.mask),
    .irq_o       (irq_o)
);

// File: tb/test_mac_irq_status.sv
`timescale 1ns/1ps
module test_mac_irq_status;
    localparam int ADDR_W = 4;
    localparam int SEC_W  = 32;
    localparam int NS_W   = 30;
    localparam int TX_W   = 18;
    localparam int RX_W   = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_en = 1'b0, wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wr_data = '0;
    logic [31:0]       rd_data;
    logic              lpi_tx_chg = 0, lpi_rx_chg = 0, lpi_flag_rd = 0;
    logic [SEC_W-1:0]  sys_sec = '0, tgt_sec = '0;
    logic [NS_W-1:0]   sys_ns = '0, tgt_ns = '0;
    logic              adv_ts_mode = 0, tgt_sec_ovf = 0, ts_ovf_rd = 0;
    logic [TX_W-1:0]   mmc_tx_irq = '0;
    logic [RX_W-1:0]   mmc_rx_irq = '0;
    logic              pmt_evt = 0;
    logic              irq_o;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    mac_irq_status #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .NS_W(NS_W),
                     .TX_W(TX_W), .RX_W(RX_W)) i_mac_irq_status (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .lpi_tx_chg(lpi_tx_chg),
        .lpi_rx_chg(lpi_rx_chg), .lpi_flag_rd(lpi_flag_rd), .sys_sec(sys_sec),
        .sys_ns(sys_ns), .tgt_sec(tgt_sec), .tgt_ns(tgt_ns),
        .adv_ts_mode(adv_ts_mode), .tgt_sec_ovf(tgt_sec_ovf), .ts_ovf_rd(ts_ovf_rd),
        .mmc_tx_irq(mmc_tx_irq), .mmc_rx_irq(mmc_rx_irq), .pmt_evt(pmt_evt),
        .irq_o(irq_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // driver: one read cycle, expected value goes to the scoreboard
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp,
                      input string req, input logic with_ovf = 1'b0);
        item_t it;
        it.exp = exp;
        it.req = req;
        sb.push_back(it);
        addr        = a;
        rd_en       = 1'b1;
        tgt_sec_ovf = with_ovf;
        tick();
        rd_en       = 1'b0;
        tgt_sec_ovf = 1'b0;
        tick();
    endtask

    task automatic wr_mask(input logic [31:0] d);
        addr = 1; wr_data = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    // monitor: compares read data one cycle after each read strobe
    always begin
        @(posedge clk);
        if (rd_en) begin
            item_t it;
            @(negedge clk);
            if (sb.size() == 0) begin
                tests++; fails++;
                $display("FAIL scoreboard: unexpected read data 0x%08h expected none", rd_data);
            end else begin
                it = sb.pop_front();
                check(it.req, rd_data, it.exp);
            end
        end
    end

    initial begin
        #(200000 * 8);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tgt_sec = 5; tgt_ns = 100;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 irq", {31'd0, irq_o}, 32'd0);
        rd(0, 32'h0, "R1 status");
        rd(1, 32'h0, "R1 mask");

        // R2 unimplemented bits
        wr_mask(32'hFFFF_FFFF);
        rd(1, 32'h0000_0678, "R2 mask readback");
        wr_mask(32'h0);

        // R3 LPI set, not cleared by status read
        lpi_tx_chg = 1; tick(); lpi_tx_chg = 0;
        rd(0, 32'h400, "R3 lpi set");
        rd(0, 32'h400, "R3 lpi kept after read");
        check("R3 irq", {31'd0, irq_o}, 32'd1);

        // R4 LPI clear and set priority
        lpi_flag_rd = 1; tick(); lpi_flag_rd = 0;
        rd(0, 32'h0, "R4 lpi clear");
        lpi_rx_chg = 1; lpi_flag_rd = 1; tick(); lpi_rx_chg = 0; lpi_flag_rd = 0;
        rd(0, 32'h400, "R4 set wins over clear");
        lpi_flag_rd = 1; tick(); lpi_flag_rd = 0;
        rd(0, 32'h0, "R4 lpi clear again");

        // R5 time comparison
        sys_sec = 4; sys_ns = 999; tick(); tick();
        rd(0, 32'h0, "R5 smaller seconds larger ns");
        sys_sec = 5; sys_ns = 99; tick();
        rd(0, 32'h0, "R5 equal seconds smaller ns");
        sys_ns = 100; tick();
        rd(0, 32'h200, "R5 equal time match");
        rd(0, 32'h0, "R5 single event");
        sys_sec = 6; sys_ns = 0; tick();
        rd(0, 32'h0, "R5 still true no new event");
        sys_sec = 0; tick();
        sys_sec = 7; tick();
        rd(0, 32'h200, "R5 new rising edge");
        rd(0, 32'h0, "R7 cleared by read");
        sys_sec = 0; sys_ns = 0; tick();

        // R6 overflow in default vs advanced mode
        tgt_sec_ovf = 1; tick(); tgt_sec_ovf = 0;
        rd(0, 32'h0, "R6 overflow ignored in default mode");
        adv_ts_mode = 1;
        tgt_sec_ovf = 1; tick(); tgt_sec_ovf = 0;
        rd(1, 32'h0, "R6 mask unaffected");
        ts_ovf_rd = 1; tick(); ts_ovf_rd = 0;
        rd(0, 32'h0, "R7 cleared by overflow-flag read");
        tgt_sec_ovf = 1; tick(); tgt_sec_ovf = 0;
        rd(0, 32'h200, "R6 overflow sets in advanced mode");

        // R7 set wins over clears
        rd(0, 32'h0, "R7 read clear before race");
        rd(0, 32'h0, "R7 read with simultaneous set", 1'b1);
        rd(0, 32'h200, "R7 set survived read clear");
        tgt_sec_ovf = 1; ts_ovf_rd = 1; tick(); tgt_sec_ovf = 0; ts_ovf_rd = 0;
        rd(0, 32'h200, "R7 set survived overflow-flag clear");
        rd(0, 32'h0, "R7 final clear");
        adv_ts_mode = 0;

        // R8 counter summaries
        mmc_tx_irq = 18'h8; tick();
        rd(0, 32'h50, "R8 tx only");
        mmc_tx_irq = '0; mmc_rx_irq = 18'h20000; tick();
        rd(0, 32'h30, "R8 rx only");
        mmc_tx_irq = 18'h1; tick();
        rd(0, 32'h70, "R8 both");
        mmc_tx_irq = '0; mmc_rx_irq = '0; tick();
        rd(0, 32'h0, "R8 none");

        // R9 power-management level
        pmt_evt = 1; tick();
        rd(0, 32'h08, "R9 pmt high");
        check("R10 irq from pmt", {31'd0, irq_o}, 32'd1);

        // R10 masking and address decode
        wr_mask(32'h08); tick();
        check("R10 irq masked", {31'd0, irq_o}, 32'd0);
        rd(5, 32'h0, "R10 unmapped address");
        lpi_tx_chg = 1; tick(); lpi_tx_chg = 0;
        check("R10 unmasked lpi", {31'd0, irq_o}, 32'd1);
        wr_mask(32'h678); tick();
        check("R10 all masked", {31'd0, irq_o}, 32'd0);
        rd(0, 32'h408, "R10 status unaffected by mask");
        pmt_evt = 0; tick();
        rd(0, 32'h400, "R9 pmt low");

        repeat (3) tick();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule